// File: doc/BRIEF.md
# Triple-Processor Restart Arbiter

This block supervises three redundant processors that run the same program side by side. Each processor drives a four-bit request made of two fields. A two-bit action code states whether the processor is taking part and whether it wants a restart. A two-bit target select says which processor the restart is meant for. The arbiter counts these requests as votes and drives one reset line and one power-enable line to each processor.

A processor may restart itself without anyone's consent. A request aimed at a peer takes effect only when two processors name the same target for the same action. A power-cycle is closed-loop: power comes back only after the current-sense input reports that the processor's supply is really down. An overcurrent flag for each processor is synchronised on chip. It removes that processor's power regardless of any vote.

The three processors form a ring. The right-hand peer of processor i is processor (i+1) mod 3, and its left-hand peer is processor (i+2) mod 3. All state is clocked by one slow supervisor clock and cleared by an active-low asynchronous reset.

Top module: `resolver_top`

## Requirements
- R1: Bits [2i+1:2i] of `actCode` carry processor i's action: 00 is offline, 11 is idle-online, 01 votes for a reset and 10 votes for a power-cycle. `online[i]` is high exactly when processor i is powered and its action code is not 00.
- R2: If processor i sends action 10 with target select 00 (self), `powerEn[i]` falls at the next rising clock edge, without any peer vote.
- R3: Action 01 with target select 00 means "power-cycle all": `powerEn` becomes 000 at the next rising clock edge.
- R4: Target select 01 names the right-hand peer, 10 the left-hand peer and 11 both peers. A single peer-directed vote has no effect. When two processors name the same target for the same action, that action takes effect at the next rising clock edge.
- R5: A granted reset raises `procReset[t]` at the next edge. The line stays high for at least one cycle and falls at the first edge at which the reset is no longer granted. A grant held for one cycle gives a pulse of exactly one cycle.
- R6: A powered-off processor stays off while a power-cycle of it is still granted or while `curOff[t]` is low. Power returns at the first edge at which both conditions are cleared.
- R7: `ocFault[t]` passes through a two-flop synchroniser. A fault that is high before edge k forces `powerEn[t]` low after edge k+2. Power stays off while the synchronised fault is high, whatever the votes.
- R8: If a power-cycle and a reset of the same target are granted in the same cycle, only the power-cycle is carried out, and `procReset[t]` stays low.
- R9: A processor that is powered off, or that sends action 00, casts no vote. `procReset[t]` is never high while `powerEn[t]` is low.
- R10: While `rstN` is low, every processor is powered, no reset is driven, and the synchroniser is cleared.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Supervisor clock |
| rstN | input | 1 | Asynchronous active-low reset |
| actCode | input | 2*NUM_PROC | Action code per processor; bits [2i+1:2i] belong to processor i |
| devSel | input | 2*NUM_PROC | Target select per processor; bits [2i+1:2i] belong to processor i |
| curOff | input | NUM_PROC | Current-sense flag: the processor's supply is confirmed off |
| ocFault | input | NUM_PROC | Asynchronous overcurrent flag per processor |
| procReset | output | NUM_PROC | Active-high reset line per processor |
| powerEn | output | NUM_PROC | Power-switch enable per processor |
| online | output | NUM_PROC | Processor is powered and taking part in voting |

## Verification
The vote decode is combinational, so `online` follows a changed request in the same cycle. Reset and power decisions are registered and become visible one rising edge after the request. The overcurrent path adds two synchroniser stages: its effect appears after the third edge, and its release also takes effect at the third edge.

The bench changes inputs only on falling edges. It then waits the exact number of falling edges that corresponds to each of these latencies before it compares outputs. In the overcurrent case it also checks one edge early, to show that the output has not yet moved. Pulse width is measured by withdrawing a grant after one cycle and checking that the reset line falls on the very next edge.

// File: rtl/resolver_pkg.sv
package resolver_pkg;

  // Action codes (bits of each processor's request).
  localparam logic [1:0] ACT_OFFLINE = 2'b00;
  localparam logic [1:0] ACT_RESET   = 2'b01;
  localparam logic [1:0] ACT_CYCLE   = 2'b10;
  localparam logic [1:0] ACT_ONLINE  = 2'b11;

  // Target select codes.
  localparam logic [1:0] SEL_SELF  = 2'b00;
  localparam logic [1:0] SEL_RIGHT = 2'b01;
  localparam logic [1:0] SEL_LEFT  = 2'b10;
  localparam logic [1:0] SEL_BOTH  = 2'b11;

  typedef enum logic {RST_RUN, RST_ACTIVE} rstState_e;
  typedef enum logic {PWR_ON, PWR_OFF} pwrState_e;

  // Strobes from the vote path into the control machines, one per target.
  typedef struct packed {
    logic resetGo;
    logic cycleGo;
  } grant_t;

endpackage

// File: rtl/vote_path.sv
module vote_path
  import resolver_pkg::*;
#(
  parameter int NUM_PROC     = 3,
  parameter int VOTES_NEEDED = 2
) (
  input  logic [2*NUM_PROC-1:0]  actCode,
  input  logic [2*NUM_PROC-1:0]  devSel,
  input  logic [NUM_PROC-1:0]    powered,
  output grant_t [NUM_PROC-1:0]  grants,
  output logic [NUM_PROC-1:0]    online
);

  logic [NUM_PROC-1:0] voting;
  logic [NUM_PROC-1:0] peerReset;   // reset vote aimed at peers
  logic [NUM_PROC-1:0] peerCycle;   // power-cycle vote aimed at peers
  logic [NUM_PROC-1:0] selfCycle;   // immediate cycle of the voter itself
  logic [NUM_PROC-1:0] cycleAll;    // reset-self reinterpreted as cycle-all
  logic [NUM_PROC-1:0] peerMask [NUM_PROC];

  // Per-voter decode.
  for (genvar j = 0; j < NUM_PROC; j++) begin : g_voter
    localparam int RIGHT = (j + 1) % NUM_PROC;
    localparam int LEFT  = (j + NUM_PROC - 1) % NUM_PROC;
    logic [1:0] act;
    logic [1:0] sel;
    logic       isSelf;

    assign act    = actCode[2*j +: 2];
    assign sel    = devSel[2*j +: 2];
    assign isSelf = (sel == SEL_SELF);

    assign voting[j]    = powered[j] && (act != ACT_OFFLINE);
    assign online[j]    = voting[j];
    assign peerReset[j] = voting[j] && (act == ACT_RESET) && !isSelf;
    assign peerCycle[j] = voting[j] && (act == ACT_CYCLE) && !isSelf;
    assign selfCycle[j] = voting[j] && (act == ACT_CYCLE) && isSelf;
    assign cycleAll[j]  = voting[j] && (act == ACT_RESET) && isSelf;

    always_comb begin
      peerMask[j] = '0;
      if (sel[0]) peerMask[j][RIGHT] = 1'b1;
      if (sel[1]) peerMask[j][LEFT]  = 1'b1;
    end
  end

  // Per-target tally.
  for (genvar t = 0; t < NUM_PROC; t++) begin : g_target
    logic [NUM_PROC-1:0] resetCol;
    logic [NUM_PROC-1:0] cycleCol;
    logic                cycleWin;

    always_comb begin
      for (int j = 0; j < NUM_PROC; j++) begin
        resetCol[j] = peerReset[j] && peerMask[j][t];
        cycleCol[j] = peerCycle[j] && peerMask[j][t];
      end
    end

    assign cycleWin = selfCycle[t] || (|cycleAll) ||
                      ($countones(cycleCol) >= VOTES_NEEDED);

    assign grants[t].cycleGo = cycleWin;
    // A power-cycle overrides a reset granted against the same target.
    assign grants[t].resetGo = !cycleWin &&
                               ($countones(resetCol) >= VOTES_NEEDED);
  end

endmodule

// File: rtl/proc_ctrl.sv
module proc_ctrl
  import resolver_pkg::*;
#(
  parameter int NUM_PROC  = 3,
  parameter int SYNC_LEN  = 2
) (
  input  logic                   clk,
  input  logic                   rstN,
  input  grant_t [NUM_PROC-1:0]  grants,
  input  logic [NUM_PROC-1:0]    curOff,
  input  logic [NUM_PROC-1:0]    ocFault,
  output logic [NUM_PROC-1:0]    powered,
  output logic [NUM_PROC-1:0]    procReset,
  output logic [NUM_PROC-1:0]    powerEn
);

  for (genvar i = 0; i < NUM_PROC; i++) begin : g_proc
    logic [SYNC_LEN-1:0] ocSync;
    logic                ocSeen;
    pwrState_e           pwrQ, pwrD;
    rstState_e           rstQ, rstD;

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) ocSync <= '0;
      else       ocSync <= {ocSync[SYNC_LEN-2:0], ocFault[i]};
    end
    assign ocSeen = ocSync[SYNC_LEN-1];

    // Power machine: fault or granted cycle turns it off; it returns only
    // once the cycle is withdrawn and the supply is confirmed down.
    always_comb begin
      pwrD = pwrQ;
      unique case (pwrQ)
        PWR_ON:  if (ocSeen || grants[i].cycleGo) pwrD = PWR_OFF;
        PWR_OFF: if (!ocSeen && !grants[i].cycleGo && curOff[i]) pwrD = PWR_ON;
        default: pwrD = PWR_OFF;
      endcase
    end

    // Reset machine: held while granted, minimum one cycle, cleared when off.
    always_comb begin
      if (pwrD == PWR_OFF)         rstD = RST_RUN;
      else if (grants[i].resetGo)  rstD = RST_ACTIVE;
      else                         rstD = RST_RUN;
    end

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        pwrQ <= PWR_ON;
        rstQ <= RST_RUN;
      end else begin
        pwrQ <= pwrD;
        rstQ <= rstD;
      end
    end

    assign powered[i]   = (pwrQ == PWR_ON);
    assign powerEn[i]   = (pwrQ == PWR_ON);
    assign procReset[i] = (rstQ == RST_ACTIVE);
  end

endmodule

// File: rtl/resolver_top.sv
module resolver_top
  import resolver_pkg::*;
#(
  parameter int NUM_PROC     = 3,
  parameter int VOTES_NEEDED = 2
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  logic [2*NUM_PROC-1:0] actCode,
  input  logic [2*NUM_PROC-1:0] devSel,
  input  logic [NUM_PROC-1:0]   curOff,
  input  logic [NUM_PROC-1:0]   ocFault,
  output logic [NUM_PROC-1:0]   procReset,
  output logic [NUM_PROC-1:0]   powerEn,
  output logic [NUM_PROC-1:0]   online
);

  grant_t [NUM_PROC-1:0] grants;
  logic [NUM_PROC-1:0]   powered;

  vote_path #(
    .NUM_PROC(NUM_PROC),
    .VOTES_NEEDED(VOTES_NEEDED)
  ) u_vote (
    .actCode(actCode),
    .devSel(devSel),
    .powered(powered),
    .grants(grants),
    .online(online)
  );

  proc_ctrl #(
    .NUM_PROC(NUM_PROC),
    .SYNC_LEN(2)
  ) u_ctrl (
    .clk(clk),
    .rstN(rstN),
    .grants(grants),
    .curOff(curOff),
    .ocFault(ocFault),
    .powered(powered),
    .procReset(procReset),
    .powerEn(powerEn)
  );

endmodule

// File: rtl/resolver_checks.sv
module resolver_checks #(
  parameter int NUM_PROC = 3
) (
  input logic                  clk,
  input logic                  rstN,
  input logic [2*NUM_PROC-1:0] actCode,
  input logic [2*NUM_PROC-1:0] devSel,
  input logic [NUM_PROC-1:0]   curOff,
  input logic [NUM_PROC-1:0]   ocFault,
  input logic [NUM_PROC-1:0]   procReset,
  input logic [NUM_PROC-1:0]   powerEn,
  input logic [NUM_PROC-1:0]   online
);

  logic [1:0] upCnt;
  logic       warm;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)              upCnt <= '0;
    else if (upCnt != 2'd3) upCnt <= upCnt + 2'd1;
  end
  assign warm = (upCnt == 2'd3);

  for (genvar i = 0; i < NUM_PROC; i++) begin : g_chk
    AST_OC_FORCES_OFF: assert property (@(posedge clk) disable iff (!rstN)
      (warm && $past(ocFault[i], 2)) |=> !powerEn[i]);                  // R7

    AST_RETURN_AFTER_OFF_FLAG: assert property (@(posedge clk) disable iff (!rstN)
      (warm && $rose(powerEn[i])) |-> $past(curOff[i]));                // R6

    AST_RESET_ONLY_POWERED: assert property (@(posedge clk) disable iff (!rstN)
      procReset[i] |-> powerEn[i]);                                     // R9

    AST_ONLINE_NEEDS_POWER: assert property (@(posedge clk) disable iff (!rstN)
      online[i] |-> powerEn[i]);                                        // R1

    AST_CYCLE_ALL: assert property (@(posedge clk) disable iff (!rstN)
      (warm && online[i] && actCode[2*i +: 2] == 2'b01 && devSel[2*i +: 2] == 2'b00)
      |=> (powerEn == '0));                                             // R3

    AST_SELF_CYCLE: assert property (@(posedge clk) disable iff (!rstN)
      (warm && online[i] && actCode[2*i +: 2] == 2'b10 && devSel[2*i +: 2] == 2'b00)
      |=> !powerEn[i]);                                                 // R2
  end

endmodule

bind resolver_top resolver_checks #(.NUM_PROC(NUM_PROC)) u_checks (
  .clk(clk),
  .rstN(rstN),
  .actCode(actCode),
  .devSel(devSel),
  .curOff(curOff),
  .ocFault(ocFault),
  .procReset(procReset),
  .powerEn(powerEn),
  .online(online)
);

// File: tb/tb_resolver_top.sv
module tb_resolver_top;

  localparam int N = 3;

  logic           clk = 1'b0;
  logic           rstN;
  logic [2*N-1:0] actCode;
  logic [2*N-1:0] devSel;
  logic [N-1:0]   curOff;
  logic [N-1:0]   ocFault;
  logic [N-1:0]   procReset;
  logic [N-1:0]   powerEn;
  logic [N-1:0]   online;

  int total = 0;
  int bad   = 0;
  int cycles = 0;

  always #4 clk = ~clk;

  resolver_top #(.NUM_PROC(N), .VOTES_NEEDED(2)) dut (
    .clk(clk), .rstN(rstN), .actCode(actCode), .devSel(devSel),
    .curOff(curOff), .ocFault(ocFault), .procReset(procReset),
    .powerEn(powerEn), .online(online)
  );

  always @(posedge clk) begin
    cycles++;
    if (cycles > 5000) begin
      bad++;
      total++;
      $display("FAIL watchdog: run hung, actual=%0d cycles expected<=5000", cycles);
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  task automatic tick(int n = 1);
    repeat (n) @(negedge clk);
  endtask

  task automatic check(string req, string what, logic [N-1:0] act, logic [N-1:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s %s: actual=%b expected=%b", req, what, act, exp);
    end
  endtask

  task automatic setReq(int p, logic [1:0] a, logic [1:0] s);
    actCode[2*p +: 2] = a;
    devSel[2*p +: 2]  = s;
  endtask

  task automatic idleAll();
    for (int p = 0; p < N; p++) setReq(p, 2'b11, 2'b00);
  endtask

  task automatic testReset();
    rstN = 1'b0; curOff = '0; ocFault = '0;
    idleAll();
    tick(2);
    check("R10", "powerEn in reset", powerEn, 3'b111);
    check("R10", "procReset in reset", procReset, 3'b000);
    rstN = 1'b1;
    tick(2);
    check("R1", "online all idle", online, 3'b111);
    setReq(2, 2'b00, 2'b00);
    #1;
    check("R1", "online with code 00", online, 3'b011);
    idleAll();
    tick();
  endtask

  task automatic testSelfCycle();
    setReq(2, 2'b10, 2'b00);
    tick();
    check("R2", "self cycle powerEn", powerEn, 3'b011);
    check("R1", "online of unpowered", online, 3'b011);
    setReq(2, 2'b11, 2'b00);
    tick();
    check("R6", "off while curOff low", powerEn, 3'b011);
    curOff[2] = 1'b1;
    tick();
    check("R6", "return after curOff", powerEn, 3'b111);
    curOff = '0;
  endtask

  task automatic testCycleAll();
    setReq(0, 2'b01, 2'b00);
    tick();
    check("R3", "cycle-all powerEn", powerEn, 3'b000);
    check("R9", "no reset while off", procReset, 3'b000);
    idleAll();
    curOff = 3'b111;
    tick();
    check("R6", "all return", powerEn, 3'b111);
    curOff = '0;
  endtask

  task automatic testPeerVotes();
    setReq(0, 2'b01, 2'b01);        // proc0 votes reset of right peer (1)
    tick(2);
    check("R4", "lone peer vote", procReset, 3'b000);
    setReq(2, 2'b01, 2'b10);        // proc2 votes reset of left peer (1)
    tick();
    check("R4", "two votes reset proc1", procReset, 3'b010);
    idleAll();
    tick();
    check("R5", "one-cycle reset pulse", procReset, 3'b000);
    setReq(0, 2'b01, 2'b11);        // both peers: 1 and 2
    setReq(1, 2'b01, 2'b01);        // right of 1 is 2
    tick();
    check("R4", "both-peers select", procReset, 3'b100);
    tick();
    check("R5", "reset held while granted", procReset, 3'b100);
    idleAll();
    tick();
    check("R5", "reset released", procReset, 3'b000);
    setReq(0, 2'b00, 2'b01);        // offline code: no vote
    setReq(2, 2'b01, 2'b10);
    tick();
    check("R9", "offline code casts no vote", procReset, 3'b000);
    idleAll();
    setReq(0, 2'b10, 2'b10);        // left of 0 is 2
    setReq(1, 2'b10, 2'b01);        // right of 1 is 2
    curOff[2] = 1'b1;
    tick();
    check("R4", "peer cycle of proc2", powerEn, 3'b011);
    tick();
    check("R6", "off while cycle granted", powerEn, 3'b011);
    idleAll();
    tick();
    check("R6", "return after withdraw", powerEn, 3'b111);
    curOff = '0;
  endtask

  task automatic testPriority();
    setReq(1, 2'b10, 2'b00);        // proc1 cycles itself
    setReq(0, 2'b01, 2'b01);        // reset votes on proc1
    setReq(2, 2'b01, 2'b10);
    tick();
    check("R8", "cycle wins powerEn", powerEn, 3'b101);
    check("R8", "cycle wins procReset", procReset, 3'b000);
    setReq(1, 2'b01, 2'b01);        // unpowered voter aims at proc2
    setReq(0, 2'b01, 2'b11);
    setReq(2, 2'b11, 2'b00);
    tick();
    check("R9", "unpowered voter ignored", procReset, 3'b000);
    check("R9", "online with proc1 off", online, 3'b101);
    idleAll();
    curOff[1] = 1'b1;
    tick();
    check("R6", "proc1 returns", powerEn, 3'b111);
    curOff = '0;
  endtask

  task automatic testOvercurrent();
    ocFault[0] = 1'b1;
    tick(2);
    check("R7", "still on after two edges", powerEn, 3'b111);
    tick();
    check("R7", "off after third edge", powerEn, 3'b110);
    curOff[0] = 1'b1;
    tick(2);
    check("R7", "held off during fault", powerEn, 3'b110);
    ocFault[0] = 1'b0;
    tick(2);
    check("R7", "off until sync clears", powerEn, 3'b110);
    tick();
    check("R7", "back on after release", powerEn, 3'b111);
    curOff = '0;
  endtask

  initial begin
    testReset();
    testSelfCycle();
    testCycleAll();
    testPeerVotes();
    testPriority();
    testOvercurrent();
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule